// File: doc/BRIEF.md
# Multicycle Load/Store Processor Core

This block is a 32-bit processor core for a nine-instruction integer subset: word load, word store, add, subtract, bitwise and, bitwise or, signed set-less-than, branch-if-equal and unconditional jump. It does not finish each instruction in one long cycle. A state machine steps every instruction through a short sequence of states, and one datapath is shared across those states. That datapath has a single unified memory for code and data, a single ALU, and holding registers that carry values from one step to the next: the instruction word, the memory read data, the two register operands and the ALU result.

Because the memory and the ALU are reused, the ALU also produces PC+4 during fetch and the branch target during decode. The instruction classes therefore take different numbers of cycles. Before the core runs, a load port fills the memory while reset is held. A read-only peek port shows any memory word. Two debug outputs show the program counter and the current state code.

Top module: `mc_core`

## Requirements
- R1: Reset is synchronous and active-low. While `rst_n` is low, the PC is 0 and `dbg_state` shows Fetch (code 0). The load port writes `load_data` into word `load_addr` only while reset is low. When the core runs, `load_en` has no effect on memory.
- R2: A store changes exactly one memory word, the one it addresses. Neighbouring words keep their values. In any cycle, at most one of instruction-register load, memory write and register write takes place.
- R3: The instruction word is split as follows: opcode in bits 31..26, rs in 25..21, rt in 20..16, rd in 15..11, function in 5..0, offset in 15..0 and jump target in 25..0. Opcodes: 0x23 load, 0x2B store, 0x00 register-register, 0x04 branch-equal, 0x02 jump. Cycles per instruction: load 5, store 4, register-register 4, branch 3, jump 3.
- R4: `dbg_state` codes: 0 Fetch, 1 Decode, 2 address calculation, 3 load read, 4 load writeback, 5 store write, 6 register-register execute, 7 register-register writeback, 8 branch, 9 jump. Fetch loads the word at the PC into the instruction register, adds 4 to the PC, and always moves on to Decode.
- R5: The PC changes only in Fetch, in a branch whose operands are equal, and in a jump.
- R6: Load and store use the address rs + sign-extended offset (a byte address; bits 1..0 are ignored). A load writes the memory word into rt. A store writes rt into memory.
- R7: A register-register instruction writes rd with the result selected by the function field: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed less-than (result 1 or 0).
- R8: A branch-equal whose rs and rt hold the same value goes to PC+4 + (sign-extended offset × 4). When the values differ, execution continues with the next word.
- R9: A jump goes to {bits 31..28 of PC+4, target, 2'b00}.
- R10: An unknown opcode, or a register-register instruction with an unknown function code, goes from Decode back to Fetch (2 cycles in all). It changes no register and no memory word.
- R11: Register 0 always reads as zero, even after an instruction tries to write it.
- R12: `peek_data` returns memory word `peek_addr` with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Memory load strobe, honoured only in reset |
| load_addr | input | AW (6) | Word index for the load port |
| load_data | input | DW (32) | Word written through the load port |
| peek_addr | input | AW (6) | Word index for the peek port |
| peek_data | output | DW (32) | Memory word at `peek_addr` |
| dbg_pc | output | DW (32) | Current program counter |
| dbg_state | output | 4 | Current state code (see R4) |

## Verification
The assertions assume that reset is low at the first clock edge and stays low long enough to fill the memory. They also assume that the memory holds only the listed instructions or deliberately invalid words, so every state sequence starts from a defined instruction register. The bench keeps to these conditions: it always enters a test by holding reset, writes all 64 words through the load port, and only then releases the core. It observes memory contents through the peek port, and it checks cycle counts by timing the intervals between visits to Fetch on `dbg_state`.

// File: rtl/mc_pkg.sv
// Package mc_pkg
// Purpose : shared encodings for the multicycle core: opcodes, function
//           codes, state codes, ALU operations and the control word.
// Assumes : 32-bit instruction word with a 6-bit opcode in bits 31..26.
package mc_pkg;

    localparam logic [5:0] OPC_LW   = 6'h23;
    localparam logic [5:0] OPC_SW   = 6'h2B;
    localparam logic [5:0] OPC_RR   = 6'h00;
    localparam logic [5:0] OPC_BEQ  = 6'h04;
    localparam logic [5:0] OPC_JMP  = 6'h02;

    localparam logic [5:0] FN_ADD   = 6'h20;
    localparam logic [5:0] FN_SUB   = 6'h22;
    localparam logic [5:0] FN_AND   = 6'h24;
    localparam logic [5:0] FN_OR    = 6'h25;
    localparam logic [5:0] FN_SLT   = 6'h2A;

    typedef enum logic [3:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_LDRD   = 4'd3,
        ST_LDWB   = 4'd4,
        ST_STWR   = 4'd5,
        ST_RREXE  = 4'd6,
        ST_RRWB   = 4'd7,
        ST_BEQ    = 4'd8,
        ST_JMP    = 4'd9
    } core_state_e;

    typedef enum logic [2:0] {
        AOP_ADD = 3'd0,
        AOP_SUB = 3'd1,
        AOP_AND = 3'd2,
        AOP_OR  = 3'd3,
        AOP_SLT = 3'd4
    } alu_op_e;

    localparam logic [1:0] SRCB_REG  = 2'd0;
    localparam logic [1:0] SRCB_FOUR = 2'd1;
    localparam logic [1:0] SRCB_IMM  = 2'd2;
    localparam logic [1:0] SRCB_IMM4 = 2'd3;

    localparam logic [1:0] NPC_ALU   = 2'd0;
    localparam logic [1:0] NPC_HOLD  = 2'd1;
    localparam logic [1:0] NPC_JUMP  = 2'd2;

    typedef struct packed {
        logic       pc_write;
        logic       pc_write_eq;
        logic       addr_from_res;
        logic       mem_write;
        logic       ir_write;
        logic       reg_write;
        logic       dst_rd;
        logic       wb_from_mem;
        logic       srca_reg;
        logic [1:0] srcb_sel;
        logic [1:0] npc_sel;
        alu_op_e    alu_op;
    } ctrl_word_t;

endpackage

// File: rtl/mc_mem.sv
// Module mc_mem
// Purpose : unified word-addressed memory for instructions and data. One
//           asynchronous read port for the datapath, one synchronous write.
//           The preload port writes only while reset is low. The peek port
//           is read-only.
// Assumes : the datapath makes at most one access per cycle.
module mc_mem #(
    parameter int DW    = 32,
    parameter int WORDS = 64,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          load_en,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    input  logic [AW-1:0] peek_addr,
    output logic [DW-1:0] peek_data
);
    logic [DW-1:0] words [WORDS];

    // write path: preload in reset, datapath store when running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (load_en) words[load_addr] <= load_data;
        end else if (we) begin
            words[addr] <= wdata;
        end
    end

    // combinational reads for the datapath and the peek port
    always_comb begin
        rdata     = words[addr];
        peek_data = words[peek_addr];
    end
endmodule

// File: rtl/mc_regfile.sv
// Module mc_regfile
// Purpose : general register file, two read ports and one write port.
//           Register 0 has no storage and reads as zero.
// Assumes : write data and address are stable at the clock edge.
module mc_regfile #(
    parameter int DW   = 32,
    parameter int NREG = 32,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] ra1,
    input  logic [RW-1:0] ra2,
    output logic [DW-1:0] rd1,
    output logic [DW-1:0] rd2,
    input  logic          we,
    input  logic [RW-1:0] wa,
    input  logic [DW-1:0] wd
);
    logic [DW-1:0] regs [1:NREG-1];

    for (genvar gi = 1; gi < NREG; gi++) begin : g_reg
        // one storage register, cleared by reset, written when addressed
        always_ff @(posedge clk) begin
            if (!rst_n)                      regs[gi] <= '0;
            else if (we && wa == RW'(gi))    regs[gi] <= wd;
        end
    end

    // read ports with register 0 forced to zero
    always_comb begin
        rd1 = (ra1 == '0) ? '0 : regs[ra1];
        rd2 = (ra2 == '0) ? '0 : regs[ra2];
    end
endmodule

// File: rtl/mc_alu.sv
// Module mc_alu
// Purpose : the single shared ALU; add, subtract, and, or, signed less-than,
//           plus a zero flag used for branch comparison.
// Assumes : overflow is ignored (wrap-around arithmetic).
module mc_alu
    import mc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_op_e       op,
    output logic [DW-1:0] y,
    output logic          zero
);
    // operation select and zero detect
    always_comb begin
        unique case (op)
            AOP_SUB: y = a - b;
            AOP_AND: y = a & b;
            AOP_OR:  y = a | b;
            AOP_SLT: y = DW'($signed(a) < $signed(b));
            default: y = a + b;
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/mc_ctrl.sv
// Module mc_ctrl
// Purpose : state machine that sequences each instruction and produces the
//           datapath control word from the current state alone, plus the
//           function field for register-register execute.
// Assumes : opcode and function come from the instruction register, which
//           is stable after Fetch.
module mc_ctrl
    import mc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  opcode,
    input  logic [5:0]  funct,
    output ctrl_word_t  ctl,
    output core_state_e state
);
    core_state_e nxt;
    logic        fn_known;
    alu_op_e     fn_op;

    // map the function field to an ALU operation
    always_comb begin
        fn_known = 1'b1;
        fn_op    = AOP_ADD;
        case (funct)
            FN_ADD:  fn_op = AOP_ADD;
            FN_SUB:  fn_op = AOP_SUB;
            FN_AND:  fn_op = AOP_AND;
            FN_OR:   fn_op = AOP_OR;
            FN_SLT:  fn_op = AOP_SLT;
            default: fn_known = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= nxt;
    end

    // next-state function
    always_comb begin
        nxt = ST_FETCH;
        case (state)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                case (opcode)
                    OPC_LW, OPC_SW: nxt = ST_ADDR;
                    OPC_RR:         nxt = fn_known ? ST_RREXE : ST_FETCH;
                    OPC_BEQ:        nxt = ST_BEQ;
                    OPC_JMP:        nxt = ST_JMP;
                    default:        nxt = ST_FETCH;
                endcase
            end
            ST_ADDR:   nxt = (opcode == OPC_LW) ? ST_LDRD : ST_STWR;
            ST_LDRD:   nxt = ST_LDWB;
            ST_RREXE:  nxt = ST_RRWB;
            default:   nxt = ST_FETCH;
        endcase
    end

    // control word per state
    always_comb begin
        ctl = '0;
        ctl.alu_op = AOP_ADD;
        case (state)
            ST_FETCH: begin
                ctl.ir_write = 1'b1;
                ctl.srcb_sel = SRCB_FOUR;
                ctl.npc_sel  = NPC_ALU;
                ctl.pc_write = 1'b1;
            end
            ST_DECODE: ctl.srcb_sel = SRCB_IMM4;
            ST_ADDR: begin
                ctl.srca_reg = 1'b1;
                ctl.srcb_sel = SRCB_IMM;
            end
            ST_LDRD:   ctl.addr_from_res = 1'b1;
            ST_LDWB: begin
                ctl.reg_write   = 1'b1;
                ctl.wb_from_mem = 1'b1;
            end
            ST_STWR: begin
                ctl.addr_from_res = 1'b1;
                ctl.mem_write     = 1'b1;
            end
            ST_RREXE: begin
                ctl.srca_reg = 1'b1;
                ctl.srcb_sel = SRCB_REG;
                ctl.alu_op   = fn_op;
            end
            ST_RRWB: begin
                ctl.reg_write = 1'b1;
                ctl.dst_rd    = 1'b1;
            end
            ST_BEQ: begin
                ctl.srca_reg    = 1'b1;
                ctl.srcb_sel    = SRCB_REG;
                ctl.alu_op      = AOP_SUB;
                ctl.pc_write_eq = 1'b1;
                ctl.npc_sel     = NPC_HOLD;
            end
            ST_JMP: begin
                ctl.pc_write = 1'b1;
                ctl.npc_sel  = NPC_JUMP;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mc_core.sv
// Module mc_core (top)
// Purpose : multicycle core; shared memory, shared ALU and holding registers
//           (instruction, memory data, operand A/B, ALU result) sequenced by
//           mc_ctrl. Only the instruction register has a load enable.
// Assumes : memory is preloaded while rst_n is low; no exceptions.
module mc_core
    import mc_pkg::*;
#(
    parameter int DW        = 32,
    parameter int MEM_WORDS = 64,
    parameter int NREG      = 32,
    localparam int AW       = $clog2(MEM_WORDS),
    localparam int RW       = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    input  logic [AW-1:0] peek_addr,
    output logic [DW-1:0] peek_data,
    output logic [DW-1:0] dbg_pc,
    output logic [3:0]    dbg_state
);
    ctrl_word_t  ctl;
    core_state_e state;

    logic [DW-1:0] pc_q, ir_q, mdr_q, a_q, b_q, res_q;
    logic [DW-1:0] mem_rdata, mem_addr_b, rf_rd1, rf_rd2;
    logic [DW-1:0] opnd_a, opnd_b, alu_y, imm_ext, pc_next, wb_data;
    logic          alu_zero, pc_we;
    logic [RW-1:0] wb_addr;
    logic          ir_we, mem_we, reg_we;

    assign ir_we  = ctl.ir_write;
    assign mem_we = ctl.mem_write;
    assign reg_we = ctl.reg_write;

    mc_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (ir_q[31:26]),
        .funct  (ir_q[5:0]),
        .ctl    (ctl),
        .state  (state)
    );

    mc_mem #(.DW(DW), .WORDS(MEM_WORDS)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (mem_addr_b[AW+1:2]),
        .we        (mem_we),
        .wdata     (b_q),
        .rdata     (mem_rdata),
        .load_en   (load_en),
        .load_addr (load_addr),
        .load_data (load_data),
        .peek_addr (peek_addr),
        .peek_data (peek_data)
    );

    mc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (ir_q[25:21]),
        .ra2   (ir_q[20:16]),
        .rd1   (rf_rd1),
        .rd2   (rf_rd2),
        .we    (reg_we),
        .wa    (wb_addr),
        .wd    (wb_data)
    );

    mc_alu #(.DW(DW)) u_alu (
        .a    (opnd_a),
        .b    (opnd_b),
        .op   (ctl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // datapath multiplexers: address, ALU operands, writeback, next PC
    always_comb begin
        imm_ext    = {{(DW-16){ir_q[15]}}, ir_q[15:0]};
        mem_addr_b = ctl.addr_from_res ? res_q : pc_q;
        opnd_a     = ctl.srca_reg ? a_q : pc_q;
        case (ctl.srcb_sel)
            SRCB_REG:  opnd_b = b_q;
            SRCB_FOUR: opnd_b = DW'(4);
            SRCB_IMM:  opnd_b = imm_ext;
            default:   opnd_b = {imm_ext[DW-3:0], 2'b00};
        endcase
        wb_addr = ctl.dst_rd ? ir_q[15:11] : ir_q[20:16];
        wb_data = ctl.wb_from_mem ? mdr_q : res_q;
        case (ctl.npc_sel)
            NPC_ALU:  pc_next = alu_y;
            NPC_HOLD: pc_next = res_q;
            default:  pc_next = {pc_q[DW-1:28], ir_q[25:0], 2'b00};
        endcase
        pc_we = ctl.pc_write | (ctl.pc_write_eq & alu_zero);
    end

    // program counter, written under control
    always_ff @(posedge clk) begin
        if (!rst_n)     pc_q <= '0;
        else if (pc_we) pc_q <= pc_next;
    end

    // instruction register, loaded only in Fetch
    always_ff @(posedge clk) begin
        if (!rst_n)     ir_q <= '0;
        else if (ir_we) ir_q <= mem_rdata;
    end

    // holding registers that load every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdr_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
            res_q <= '0;
        end else begin
            mdr_q <= mem_rdata;
            a_q   <= rf_rd1;
            b_q   <= rf_rd2;
            res_q <= alu_y;
        end
    end

    assign dbg_pc    = pc_q;
    assign dbg_state = state;
endmodule

// File: rtl/mc_core_chk.sv
// Module mc_core_chk
// Purpose : temporal checks on the core's sequencing and PC behaviour,
//           bound into every mc_core instance.
// Assumes : reset is low at the first clock edge.
module mc_core_chk
    import mc_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    state,
    input logic [DW-1:0] pc,
    input logic          ir_we,
    input logic          mem_we,
    input logic          reg_we
);
    // R1: one edge in reset leaves PC at 0 and the FSM in Fetch
    a_r1_reset_home: assert property (@(posedge clk)
        !rst_n |=> (pc == '0 && state == ST_FETCH));

    // R2: instruction load, memory write and register write never coincide
    a_r2_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ir_we, mem_we, reg_we}));

    // R4: Fetch is always followed by Decode
    a_r4_fetch_decode: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FETCH |=> state == ST_DECODE);

    // R4: Fetch advances the PC by one word
    a_r4_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FETCH |=> pc == $past(pc) + DW'(4));

    // R5: states other than Fetch, branch and jump leave the PC alone
    a_r5_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_DECODE, ST_ADDR, ST_LDRD, ST_LDWB, ST_STWR,
                       ST_RREXE, ST_RRWB}) |=> $stable(pc));

    // R3: address calculation leads to a load read or a store write
    a_r3_addr_next: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ADDR |=> (state == ST_LDRD || state == ST_STWR));

    // R3: load read is followed by load writeback
    a_r3_load_wb: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_LDRD |=> state == ST_LDWB);
endmodule

bind mc_core mc_core_chk #(.DW(DW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .state  (dbg_state),
    .pc     (dbg_pc),
    .ir_we  (ir_we),
    .mem_we (mem_we),
    .reg_we (reg_we)
);

// File: tb/tb_mc_core.sv
module tb_mc_core;
    localparam int CLK_P = 10;
    localparam int AW    = 6;
    localparam int NW    = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_en = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [31:0]   load_data = '0;
    logic [AW-1:0] peek_addr = '0;
    logic [31:0]   peek_data;
    logic [31:0]   dbg_pc;
    logic [3:0]    dbg_state;

    int checks = 0;
    int fails  = 0;
    logic [31:0] img [NW];
    int lens [16];
    int nlens;

    always #(CLK_P/2) clk = ~clk;

    mc_core dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .peek_addr(peek_addr), .peek_data(peek_data),
        .dbg_pc(dbg_pc), .dbg_state(dbg_state)
    );

    // ALU vector table: function code, operand 1, operand 2, expected
    localparam int NV = 6;
    localparam logic [5:0]  V_FN [NV] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A, 6'h2A};
    localparam logic [31:0] V_A  [NV] = '{32'd5, 32'd3, 32'hF0F0F0F0, 32'h0F0F0000,
                                          32'hFFFFFFFF, 32'd5};
    localparam logic [31:0] V_B  [NV] = '{32'd7, 32'd10, 32'hFF00FF00, 32'h000000FF,
                                          32'd1, 32'hFFFFFFFD};
    localparam logic [31:0] V_Y  [NV] = '{32'd12, 32'hFFFFFFF9, 32'hF000F000,
                                          32'h0F0F00FF, 32'd1, 32'd0};
    localparam int ALU_LENS [5] = '{5, 5, 4, 4, 3};
    localparam int CTL_LENS [10] = '{5, 3, 3, 4, 2, 2, 4, 4, 4, 3};

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs,
                                          logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt,
                                          logic [4:0] rd, logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // hold reset, preload the whole image, check the reset state, release
    task automatic boot();
        rst_n = 1'b0;
        for (int i = 0; i < NW; i++) begin
            @(negedge clk);
            load_en = 1'b1; load_addr = AW'(i); load_data = img[i];
        end
        @(negedge clk);
        load_en = 1'b0;
        chk("R1 pc in reset", dbg_pc, 32'd0);
        chk("R1 state in reset", {28'd0, dbg_state}, 32'd0);
        rst_n = 1'b1;
    endtask

    // run, recording cycles between successive Fetch visits
    task automatic run_trace(int ncyc);
        int len = 0;
        bit started = 1'b0;
        nlens = 0;
        for (int c = 0; c < ncyc; c++) begin
            if (dbg_state == 4'd0 && started && nlens < 16) begin
                lens[nlens] = len; nlens++; len = 0;
            end
            len++; started = 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic peek(int w, output logic [31:0] v);
        peek_addr = AW'(w);
        #1 v = peek_data;
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        // table walk: lw, lw, op, sw, j-self for each ALU vector (R3 R6 R7)
        for (int k = 0; k < NV; k++) begin
            for (int i = 0; i < NW; i++) img[i] = 32'd0;
            img[0] = enc_i(6'h23, 5'd0, 5'd1, 16'h00C0);
            img[1] = enc_i(6'h23, 5'd0, 5'd2, 16'h00C4);
            img[2] = enc_r(5'd1, 5'd2, 5'd3, V_FN[k]);
            img[3] = enc_i(6'h2B, 5'd0, 5'd3, 16'h00C8);
            img[4] = {6'h02, 26'd4};
            img[48] = V_A[k]; img[49] = V_B[k]; img[50] = 32'hA5A5A5A5;
            boot();
            peek(48, v);
            chk("R12 peek of preloaded word", v, V_A[k]);
            run_trace(30);
            peek(50, v);
            chk("R7 R6 alu result stored", v, V_Y[k]);
            peek(51, v);
            chk("R2 neighbour word untouched", v, 32'd0);
            for (int j = 0; j < 5; j++)
                chk("R3 cycles per instruction", 32'(lens[j]), 32'(ALU_LENS[j]));
        end

        // R1: load port ignored while running
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            load_en = 1'b1; load_addr = AW'(60); load_data = 32'hDEADBEEF;
        end
        @(negedge clk);
        load_en = 1'b0;
        peek(60, v);
        chk("R1 load_en ignored out of reset", v, 32'd0);

        // control-flow program: branches, invalid words, r0, jump
        for (int i = 0; i < NW; i++) img[i] = 32'd0;
        img[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'h00C0);
        img[1]  = enc_i(6'h04, 5'd1, 5'd0, 16'd5);
        img[2]  = enc_i(6'h04, 5'd0, 5'd0, 16'd1);
        img[3]  = enc_i(6'h2B, 5'd0, 5'd1, 16'h00C8);
        img[4]  = enc_i(6'h2B, 5'd0, 5'd1, 16'h00CC);
        img[5]  = enc_i(6'h3F, 5'd1, 5'd2, 16'h0000);
        img[6]  = enc_r(5'd1, 5'd1, 5'd1, 6'h3F);
        img[7]  = enc_r(5'd1, 5'd1, 5'd0, 6'h20);
        img[8]  = enc_i(6'h2B, 5'd0, 5'd0, 16'h00D0);
        img[9]  = enc_i(6'h2B, 5'd0, 5'd1, 16'h00D4);
        img[10] = {6'h02, 26'd10};
        img[48] = 32'd7; img[50] = 32'h55; img[52] = 32'h99;
        boot();
        run_trace(50);
        for (int j = 0; j < 10; j++)
            chk("R3 R10 cycles per instruction", 32'(lens[j]), 32'(CTL_LENS[j]));
        peek(50, v);
        chk("R8 taken branch skipped store", v, 32'h55);
        peek(51, v);
        chk("R8 branch target store", v, 32'd7);
        peek(52, v);
        chk("R11 register 0 reads zero", v, 32'd0);
        peek(53, v);
        chk("R10 invalid words left r1 intact", v, 32'd7);
        for (int c = 0; c < 8 && dbg_state != 4'd0; c++) @(negedge clk);
        chk("R9 jump target pc", dbg_pc, 32'd40);
        chk("R5 parked in fetch", {28'd0, dbg_state}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule